// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits on the master side of a pipelined system bus. It generates the address and the transfer-type code for every beat of one burst. The caller presents a start address, a burst kind, a transfer size and, for open-ended incrementing bursts, a beat count. A one-cycle start pulse launches the burst. The sequencer then walks the address phase one beat at a time. It moves on only in cycles where the bus ready input is high.

Bursts can be single transfers, open-ended incrementing bursts, or fixed 4-, 8- or 16-beat bursts. Fixed bursts either increment or wrap. A wrapping burst folds its address inside an aligned window whose size is the beat count times the transfer size in bytes. An open-ended incrementing burst that would step into the next 1 KB region ends at that point and carries on with a fresh first beat. The caller can ask for idle-but-owned (BUSY) cycles between beats through a stall request input.

The controller has four states:
- IDLE drives the idle transfer code and waits for start.
- BEAT drives a NONSEQ or SEQ beat.
- BUSY drives the busy code with the next beat's address.
- DONE drives the idle code and raises the done flag.

The transitions are:
- IDLE to BEAT on start.
- BEAT to BEAT when a non-final beat is accepted without a stall request.
- BEAT to BUSY when a non-final beat is accepted with a stall request.
- BEAT to DONE when the final beat is accepted.
- BUSY to BEAT when ready is high and no stall is requested.
- DONE to IDLE unconditionally.

In every other case the state holds.

Top module: `burst_addr_seq`

## Requirements
- R1: The burst kind code sets the beat count: 000 gives 1 beat, 010 and 011 give 4, 100 and 101 give 8, 110 and 111 give 16, and 001 gives `incr_len` beats (a value of 0 counts as 1 beat). Even codes other than 000 wrap, and odd codes increment.
- R2: The transfer code is 10 (NONSEQ) on the first beat of a burst and 11 (SEQ) on each later beat. The exception is the restart case in R7.
- R3: In incrementing bursts, each beat's address is the previous beat's address plus 2^`xfer_size` bytes.
- R4: In wrapping bursts, the address advances by 2^`xfer_size` inside an aligned window of beats × 2^`xfer_size` bytes. Address bits above the window stay fixed. For example, a 4-beat wrap of 4-byte words from 0x34 visits 0x34, 0x38, 0x3C and 0x30.
- R5: While `bus_ready` is low, the transfer code and address held in a beat or BUSY cycle do not change.
- R6: If `stall_req` is high when a non-final beat is accepted, the next cycle shows code 01 (BUSY) with the next beat's address, and no beat is consumed. BUSY holds until a cycle with `bus_ready` high and `stall_req` low. The next cycle then presents that same address as a beat.
- R7: In an open-ended incrementing burst, a beat whose address lies in a different 1 KB region than the previous beat is marked NONSEQ instead of SEQ.
- R8: One cycle after the final beat is accepted, the code is 00 (IDLE) and `done_o` is high. `done_o` is high for exactly that one cycle.
- R9: `start` is ignored in every state except IDLE.
- R10: After reset, the code is 00, `done_o` is low and the address output is 0.
- R11: `burst_o` and `size_o` show the kind and size latched at start, and they do not change during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a burst when the sequencer is idle |
| start_addr | input | ADDR_W | Address of the first beat |
| burst_kind | input | 3 | Burst kind code (see R1) |
| xfer_size | input | 3 | Transfer size, log2 of the byte count |
| incr_len | input | LEN_W | Beat count for an open-ended incrementing burst |
| stall_req | input | 1 | Requests BUSY cycles after the current beat |
| bus_ready | input | 1 | High when the bus accepts the current cycle |
| htrans_o | output | 2 | Transfer code: 00 idle, 01 busy, 10 first beat, 11 follow-on beat |
| haddr_o | output | ADDR_W | Beat address |
| burst_o | output | 3 | Latched burst kind |
| size_o | output | 3 | Latched transfer size |
| done_o | output | 1 | One-cycle pulse after the final beat |

## Verification
Directed bursts cover the known wrap sequence from 0x34 and the wrap window for each beat count at byte, halfword and doubleword sizes. They also cover an open-ended burst that walks across a 1 KB line, which separates a correct NONSEQ restart from a plain SEQ stream. Random bursts combine random kinds, sizes and lengths with ready dropping at random and random stall requests. This shows whether holding on low ready and BUSY insertion leave the beat index untouched. Start pulses with junk addresses during live bursts confirm that only the idle state accepts a launch.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    typedef enum logic [2:0] {
        BK_SINGLE = 3'b000,
        BK_INCR   = 3'b001,
        BK_WRAP4  = 3'b010,
        BK_INCR4  = 3'b011,
        BK_WRAP8  = 3'b100,
        BK_INCR8  = 3'b101,
        BK_WRAP16 = 3'b110,
        BK_INCR16 = 3'b111
    } burst_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BEAT,
        S_BUSY,
        S_DONE
    } seq_state_t;

    // log2 of the beat count for fixed-length kinds, 0 otherwise
    function automatic logic [2:0] fixed_beats_log2(input logic [2:0] kind);
        unique case (kind[2:1])
            2'b01:   return 3'd2;
            2'b10:   return 3'd3;
            2'b11:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic kind_wraps(input logic [2:0] kind);
        return (kind[0] == 1'b0) && (kind[2:1] != 2'b00);
    endfunction

endpackage

// File: rtl/seq_next_addr.sv
module seq_next_addr #(
    parameter int ADDR_W = 32,
    parameter int KB_LOG = 10,
    parameter bit KB_GUARD = 1'b1
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        kind,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] next_addr,
    output logic              region_cross
);
    import bseq_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] incd;
    logic [3:0]        span_log;
    logic [ADDR_W-1:0] win_mask;

    always_comb begin
        step      = ONE << size;
        incd      = cur_addr + step;
        span_log  = 4'(fixed_beats_log2(kind)) + 4'(size);
        win_mask  = (ONE << span_log) - ONE;
        if (kind_wraps(kind)) begin
            next_addr = (cur_addr & ~win_mask) | (incd & win_mask);
        end else begin
            next_addr = incd;
        end
    end

    generate
        if (KB_GUARD) begin : g_guard
            assign region_cross = (kind == BK_INCR) &&
                (next_addr[ADDR_W-1:KB_LOG] != cur_addr[ADDR_W-1:KB_LOG]);
        end else begin : g_noguard
            assign region_cross = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/seq_beat_cnt.sv
module seq_beat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q <= {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int KB_LOG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        burst_kind,
    input  logic [2:0]        xfer_size,
    input  logic [LEN_W-1:0]  incr_len,
    input  logic              stall_req,
    input  logic              bus_ready,
    output logic [1:0]        htrans_o,
    output logic [ADDR_W-1:0] haddr_o,
    output logic [2:0]        burst_o,
    output logic [2:0]        size_o,
    output logic              done_o
);
    import bseq_pkg::*;

    localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        kind_q;
    logic [2:0]        size_q;
    logic              first_q;

    logic              launch;
    logic              accept;
    logic              last_beat;
    logic [CNT_W-1:0]  beat_total;
    logic [ADDR_W-1:0] nxt_addr;
    logic              crossing;

    assign launch = (state_q == S_IDLE) && start;
    assign accept = (state_q == S_BEAT) && bus_ready;

    always_comb begin
        unique case (burst_kind)
            BK_SINGLE: beat_total = CNT_W'(1);
            BK_INCR:   beat_total = (incr_len == '0) ? CNT_W'(1) : CNT_W'(incr_len);
            default:   beat_total = CNT_W'(1) << fixed_beats_log2(burst_kind);
        endcase
    end

    seq_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (beat_total),
        .dec      (accept),
        .last     (last_beat)
    );

    seq_next_addr #(.ADDR_W(ADDR_W), .KB_LOG(KB_LOG), .KB_GUARD(1'b1)) u_nxt (
        .cur_addr     (addr_q),
        .kind         (kind_q),
        .size         (size_q),
        .next_addr    (nxt_addr),
        .region_cross (crossing)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_BEAT;
            S_BEAT: begin
                if (bus_ready) begin
                    if (last_beat)      state_d = S_DONE;
                    else if (stall_req) state_d = S_BUSY;
                    else                state_d = S_BEAT;
                end
            end
            S_BUSY: if (bus_ready && !stall_req) state_d = S_BEAT;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // beat datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            kind_q  <= BK_SINGLE;
            size_q  <= '0;
            first_q <= 1'b0;
        end else if (launch) begin
            addr_q  <= start_addr;
            kind_q  <= burst_kind;
            size_q  <= xfer_size;
            first_q <= 1'b1;
        end else if (accept && !last_beat) begin
            addr_q  <= nxt_addr;
            first_q <= crossing;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_BEAT:  htrans_o = first_q ? TR_NONSEQ : TR_SEQ;
            S_BUSY:  htrans_o = TR_BUSY;
            default: htrans_o = TR_IDLE;
        endcase
        haddr_o = addr_q;
        burst_o = kind_q;
        size_o  = size_q;
        done_o  = (state_q == S_DONE);
    end

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall_req,
    input logic              bus_ready,
    input logic [1:0]        htrans_o,
    input logic [ADDR_W-1:0] haddr_o,
    input logic [2:0]        burst_o,
    input logic [2:0]        size_o,
    input logic              done_o
);
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans_o != 2'b00 && !bus_ready) |=> ($stable(htrans_o) && $stable(haddr_o))); // R5

    AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans_o == 2'b00) |=> (htrans_o == 2'b00 || htrans_o == 2'b10)); // R2

    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans_o == 2'b11) |-> ($stable(burst_o) && $stable(size_o))); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (htrans_o == 2'b00)); // R8

    AST_BUSY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans_o == 2'b01 && bus_ready && !stall_req) |=>
        (htrans_o[1] && (haddr_o == $past(haddr_o)))); // R6

endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W)) u_bseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_req (stall_req),
    .bus_ready (bus_ready),
    .htrans_o  (htrans_o),
    .haddr_o   (haddr_o),
    .burst_o   (burst_o),
    .size_o    (size_o),
    .done_o    (done_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [2:0]  burst_kind = '0;
    logic [2:0]  xfer_size = '0;
    logic [7:0]  incr_len = '0;
    logic        stall_req = 1'b0;
    logic        bus_ready = 1'b0;
    logic [1:0]  htrans_o;
    logic [31:0] haddr_o;
    logic [2:0]  burst_o;
    logic [2:0]  size_o;
    logic        done_o;

    int total_n = 0;
    int bad_n = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .burst_kind(burst_kind), .xfer_size(xfer_size), .incr_len(incr_len),
        .stall_req(stall_req), .bus_ready(bus_ready), .htrans_o(htrans_o),
        .haddr_o(haddr_o), .burst_o(burst_o), .size_o(size_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad_n++;
            $display("FAIL watchdog: run did not end act=%0d exp<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total_n, bad_n);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int beat_total(input logic [2:0] kd, input logic [7:0] ln);
        case (kd)
            3'b000: return 1;
            3'b001: return (ln == 0) ? 1 : int'(ln);
            3'b010, 3'b011: return 4;
            3'b100, 3'b101: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] ref_addr(input logic [31:0] sa, input logic [2:0] kd,
                                             input logic [2:0] sz, input int k);
        logic [31:0] a = sa;
        logic [31:0] bytes = 32'd1 << sz;
        logic [31:0] span = bytes * beat_total(kd, 8'd1);
        bit wraps = (kd == 3'b010) || (kd == 3'b100) || (kd == 3'b110);
        for (int i = 0; i < k; i++) begin
            if (wraps) a = (a & ~(span - 1)) | ((a + bytes) & (span - 1));
            else       a = a + bytes;
        end
        return a;
    endfunction

    // phases of the bench model: 0 beat, 1 busy, 2 done
    task automatic run_burst(input logic [31:0] sa, input logic [2:0] kd, input logic [2:0] sz,
                             input logic [7:0] ln, input int rdy_pct, input int stl_pct,
                             input bit junk);
        int total = beat_total(kd, ln);
        int k = 0;
        int phase = 0;
        bit rdy;
        bit stl;
        bit prev_rdy = 1'b1;
        bit junk_seen = 1'b0;
        logic [1:0]  exp_tr;
        logic [31:0] exp_a;
        string tag;
        string atag;
        bit wraps = (kd == 3'b010) || (kd == 3'b100) || (kd == 3'b110);
        atag = wraps ? "R4" : ((kd == 3'b001) ? "R3 R7" : "R3");
        @(negedge clk);
        start = 1'b1; start_addr = sa; burst_kind = kd; xfer_size = sz; incr_len = ln;
        stall_req = 1'b0; bus_ready = ($urandom_range(99) < rdy_pct);
        prev_rdy = 1'b1;
        forever begin
            @(negedge clk);
            start = 1'b0;
            start_addr = $urandom;
            burst_kind = 3'($urandom); xfer_size = 3'($urandom); incr_len = 8'($urandom);
            if (phase == 2) begin
                chk(htrans_o == 2'b00, "R8", "trans after last", 32'(htrans_o), 0);
                chk(done_o == 1'b1, "R1 R8", "done pulse", 32'(done_o), 1);
                bus_ready = 1'b1; stall_req = 1'b0;
                @(negedge clk);
                chk(done_o == 1'b0, "R8", "done width", 32'(done_o), 0);
                chk(htrans_o == 2'b00, "R8", "idle after done", 32'(htrans_o), 0);
                return;
            end
            exp_a = ref_addr(sa, kd, sz, k);
            if (phase == 1) exp_tr = 2'b01;
            else if (k == 0) exp_tr = 2'b10;
            else if (kd == 3'b001 && (exp_a >> 10) != (ref_addr(sa, kd, sz, k - 1) >> 10))
                exp_tr = 2'b10;
            else exp_tr = 2'b11;
            tag = !prev_rdy ? "R5" : ((phase == 1) ? "R6" : "R2");
            chk(htrans_o == exp_tr, tag, "trans", 32'(htrans_o), 32'(exp_tr));
            chk(haddr_o == exp_a, junk_seen ? {atag, " R9"} : atag, "addr", haddr_o, exp_a);
            chk(burst_o == kd && size_o == sz, "R11", "ctrl", {26'd0, burst_o, size_o},
                {26'd0, kd, sz});
            chk(done_o == 1'b0, "R8", "done early", 32'(done_o), 0);
            rdy = ($urandom_range(99) < rdy_pct);
            stl = ($urandom_range(99) < stl_pct);
            bus_ready = rdy; stall_req = stl;
            if (junk && $urandom_range(3) == 0) begin
                start = 1'b1; junk_seen = 1'b1;
            end
            prev_rdy = rdy;
            if (phase == 0 && rdy) begin
                k++;
                if (k == total) phase = 2;
                else if (stl) phase = 1;
            end else if (phase == 1 && rdy && !stl) begin
                phase = 0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk(htrans_o == 2'b00, "R10", "reset trans", 32'(htrans_o), 0);
        chk(done_o == 1'b0, "R10", "reset done", 32'(done_o), 0);
        chk(haddr_o == 32'd0, "R10", "reset addr", haddr_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(htrans_o == 2'b00, "R10", "idle after reset", 32'(htrans_o), 0);

        // directed corners
        run_burst(32'h34, 3'b010, 3'd2, 8'd0, 100, 0, 1'b0);     // R4 known sequence
        run_burst(32'h100, 3'b011, 3'd2, 8'd0, 100, 0, 1'b0);    // R1 R3 INCR4
        run_burst(32'h77, 3'b000, 3'd0, 8'd0, 100, 0, 1'b0);     // R1 single
        run_burst(32'h3F8, 3'b001, 3'd2, 8'd6, 100, 0, 1'b0);    // R7 crosses 1 KB
        run_burst(32'h500, 3'b001, 3'd1, 8'd0, 100, 0, 1'b0);    // R1 length 0
        run_burst(32'h1E, 3'b100, 3'd1, 8'd0, 100, 0, 1'b0);     // R4 WRAP8 halfword
        run_burst(32'h2B, 3'b110, 3'd0, 8'd0, 100, 0, 1'b0);     // R4 WRAP16 byte
        run_burst(32'h1088, 3'b110, 3'd3, 8'd0, 60, 40, 1'b1);   // R4 R6 R9 WRAP16 dword
        run_burst(32'h800, 3'b111, 3'd3, 8'd0, 50, 50, 1'b1);    // R5 R6 INCR16
        run_burst(32'h7F0, 3'b001, 3'd3, 8'd9, 40, 50, 1'b1);    // R7 with stalls

        // random bursts
        for (int n = 0; n < 60; n++) begin
            logic [2:0]  kd = 3'($urandom);
            logic [2:0]  sz = 3'($urandom_range(3));
            logic [7:0]  ln = 8'($urandom_range(20));
            logic [31:0] span = (32'd1 << sz) * 32'(beat_total(kd, 8'd1));
            logic [31:0] sa = $urandom & ~((32'd1 << sz) - 1);
            if (kd[0] && kd != 3'b001) sa = sa & ~(span - 1);
            if (kd == 3'b001 && n % 3 == 0) sa = (sa | 32'h3E0) & ~((32'd1 << sz) - 1);
            run_burst(sa, kd, sz, ln, 30 + int'($urandom_range(70)),
                      int'($urandom_range(60)), 1'b1);
            repeat ($urandom_range(2)) begin
                @(negedge clk);
                chk(htrans_o == 2'b00, "R9", "idle between bursts", 32'(htrans_o), 0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

endmodule